// File: doc/BRIEF.md
# Coprocessor DMA Write-Type Selector

This block sits between a coprocessor's result path and the memory bus. It takes one write request at a time and turns it into a series of bus write transactions, one per cache line touched. A request names its class, a start address, a length and a 64-bit word. The class is one of status block, completion word, parameter block or output data. Addresses and lengths count 8-byte words. A cache line is 128 bytes, which is sixteen 8-byte slots.

Each class has its own mode field. Together with the position of a piece inside its line, the mode decides the transaction type of that piece. The type is a partial write, a full-line write or a full-line cache-inject write. Some modes pad an aligned line out to the full sixteen slots. Completion modes 1 and 2 replicate the 64-bit word across a whole line. Transactions leave through a valid/ready handshake at a rate of at most one per cycle.

Top module: `dwsel_top`

## Requirements
- R1: Addresses and lengths are in 8-byte words, and a line is 16 words. Every request except a completion is cut into pieces. A piece runs from the current word to the end of the request or the end of its line, whichever comes first. Each transaction carries:
  - `out_line_o`: the word address shifted right by 4.
  - `out_mask_o`: bit s set for each slot s of the line that is written.
  - `out_type_o`: 0 for partial, 1 for full line, 2 for cache inject.
  - `out_last_o`: set only on the final piece of the request.
- R2: Status class (code 0) selects its type from `cfg_sts_i`, with the exact slot mask:
  - mode 0: always partial.
  - mode 1: inject when the piece ends on slot 15, partial otherwise.
  - mode 2: full when the piece ends on slot 15, partial otherwise.
- R3: Completion class (code 1) makes exactly one transaction, always marked last, with `out_wrd_o` equal to the request word. Its behaviour depends on `cfg_cmp_i`:
  - mode 0: a partial write with only the slot of the start address enabled.
  - modes 1 and 2: all 16 slots enabled, as inject (mode 1) or full (mode 2).
- R4: Parameter class (code 2) with `cfg_prm_i` 0 or 1:
  - mode 0: full for a piece that fills an aligned line, partial with the exact mask otherwise.
  - mode 1: full with all 16 slots (padded) for any piece that starts at slot 0, partial with the exact mask otherwise.
- R5: Parameter class with `cfg_prm_i` 2 or 3:
  - mode 2: inject only for a piece that fills an aligned line, partial otherwise.
  - mode 3: inject with all 16 slots (padded) for any piece that starts at slot 0, partial otherwise.
- R6: Output-data class (code 3) with the 1-bit `cfg_out_i`:
  - 0: full for a complete aligned line, partial otherwise.
  - 1: inject for a complete aligned line, partial otherwise.
- R7: Mode code 3 on the status or completion field behaves as mode 0. Accepting such a request sets `cfg_err_o` in the next cycle, and the flag stays set until reset.
- R8: While `out_valid_o` is high and `out_ready_i` is low, every output field stays unchanged in the next cycle.
- R9: `req_ready_o` is low from the cycle after a non-empty request is accepted until the last piece is taken. It is high again in the cycle that follows.
- R10: A zero-length request is accepted, produces no transaction, and leaves `req_ready_o` high in the next cycle.
- R11: After reset `out_valid_o` is 0, `req_ready_o` is 1 and `cfg_err_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Block can take a request |
| req_cls_i | input | 2 | Class: 0 status, 1 completion, 2 parameter, 3 output data |
| req_addr_i | input | ADDR_W | Start word address |
| req_len_i | input | LEN_W | Length in words |
| req_wrd_i | input | WORD_W | Completion word |
| cfg_sts_i | input | 2 | Status mode |
| cfg_cmp_i | input | 2 | Completion mode |
| cfg_prm_i | input | 2 | Parameter mode |
| cfg_out_i | input | 1 | Output-data mode |
| out_valid_o | output | 1 | Transaction valid |
| out_ready_i | input | 1 | Bus takes the transaction |
| out_line_o | output | ADDR_W-4 | Line address |
| out_mask_o | output | 16 | Slot enables |
| out_type_o | output | 2 | Transaction type |
| out_last_o | output | 1 | Final piece of the request |
| out_wrd_o | output | WORD_W | Word of the request, replicated by the bus for completion lines |
| cfg_err_o | output | 1 | Sticky invalid-mode flag |

## Verification
Every class is swept through every mode code, all sixteen start slots and a set of lengths. The lengths include zero, a single word, lengths that end exactly on a line boundary, lengths one word past a boundary, and spans of several lines. Start slot 0 against a nonzero slot separates the alignment-driven choices. A piece that ends on slot 15 against one that stops short separates the end-of-line choices in the status class. Whole lines against short aligned pieces separate the padded modes from the unpadded ones. The downstream ready signal is throttled in a repeating pattern, so pieces are checked while held and after release.

// File: rtl/dwsel_pkg.sv
`timescale 1ns/1ps
package dwsel_pkg;
  typedef enum logic [1:0] {CLS_STS = 2'd0, CLS_CMP = 2'd1, CLS_PRM = 2'd2, CLS_OUT = 2'd3} cls_e;
  typedef enum logic [1:0] {WT_PART = 2'd0, WT_FULL = 2'd1, WT_INJ = 2'd2} wtype_e;
endpackage

// File: rtl/dwsel_piece.sv
`timescale 1ns/1ps
module dwsel_piece #(
  parameter int SLOTS = 16,
  parameter int LEN_W = 8,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int CNT_W = SLOT_W + 1
) (
  input  logic [SLOT_W-1:0] off_i,
  input  logic [LEN_W-1:0]  rem_i,
  input  logic              single_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [SLOTS-1:0]  mask_o,
  output logic              aligned_o,
  output logic              whole_o,
  output logic              eol_o
);
  logic [LEN_W:0]   space, rem_x;
  logic             rem_short;
  logic [CNT_W:0]   lo, hi;

  assign space     = (LEN_W+1)'(SLOTS) - (LEN_W+1)'(off_i);
  assign rem_x     = {1'b0, rem_i};
  assign rem_short = rem_x < space;

  always_comb begin
    if (single_i)       cnt_o = CNT_W'(1);
    else if (rem_short) cnt_o = rem_i[CNT_W-1:0];
    else                cnt_o = space[CNT_W-1:0];
  end

  assign lo = (CNT_W+1)'(off_i);
  assign hi = lo + (CNT_W+1)'(cnt_o);

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    assign mask_o[s] = ((CNT_W+1)'(s) >= lo) && ((CNT_W+1)'(s) < hi);
  end

  assign aligned_o = (off_i == '0);
  assign whole_o   = aligned_o && (cnt_o == CNT_W'(SLOTS));
  assign eol_o     = (hi == (CNT_W+1)'(SLOTS));
endmodule

// File: rtl/dwsel_type.sv
`timescale 1ns/1ps
module dwsel_type
  import dwsel_pkg::*;
(
  input  logic [1:0] cls_i,
  input  logic [1:0] mode_i,
  input  logic       aligned_i,
  input  logic       whole_i,
  input  logic       eol_i,
  output wtype_e     wt_o,
  output logic       pad_o
);
  always_comb begin
    wt_o  = WT_PART;
    pad_o = 1'b0;
    case (cls_e'(cls_i))
      CLS_STS: begin
        if (mode_i == 2'd1 && eol_i) wt_o = WT_INJ;
        if (mode_i == 2'd2 && eol_i) wt_o = WT_FULL;
      end
      CLS_CMP: begin
        if (mode_i == 2'd1) begin wt_o = WT_INJ;  pad_o = 1'b1; end
        if (mode_i == 2'd2) begin wt_o = WT_FULL; pad_o = 1'b1; end
      end
      CLS_PRM: begin
        case (mode_i)
          2'd0: if (whole_i) wt_o = WT_FULL;
          2'd1: if (aligned_i) begin wt_o = WT_FULL; pad_o = 1'b1; end
          2'd2: if (whole_i) wt_o = WT_INJ;
          default: if (aligned_i) begin wt_o = WT_INJ; pad_o = 1'b1; end
        endcase
      end
      default: begin
        if (whole_i) wt_o = mode_i[0] ? WT_INJ : WT_FULL;
      end
    endcase
  end
endmodule

// File: rtl/dwsel_top.sv
`timescale 1ns/1ps
module dwsel_top
  import dwsel_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int LEN_W  = 8,
  parameter int SLOTS  = 16,
  parameter int WORD_W = 64,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int LINE_W = ADDR_W - SLOT_W,
  localparam int CNT_W  = SLOT_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [1:0]        req_cls_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic [WORD_W-1:0] req_wrd_i,
  input  logic [1:0]        cfg_sts_i,
  input  logic [1:0]        cfg_cmp_i,
  input  logic [1:0]        cfg_prm_i,
  input  logic              cfg_out_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [LINE_W-1:0] out_line_o,
  output logic [SLOTS-1:0]  out_mask_o,
  output logic [1:0]        out_type_o,
  output logic              out_last_o,
  output logic [WORD_W-1:0] out_wrd_o,
  output logic              cfg_err_o
);
  logic              busy_q, err_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  rem_q;
  logic [1:0]        cls_q, mode_q;
  logic [WORD_W-1:0] wrd_q;

  logic [CNT_W-1:0]  cnt;
  logic [SLOTS-1:0]  exact;
  logic              aligned, whole, eol, pad, single, last, accept, fire;
  wtype_e            wt;
  logic [1:0]        mode_in;
  logic              bad_in;

  assign single = (cls_q == CLS_CMP);

  dwsel_piece #(.SLOTS(SLOTS), .LEN_W(LEN_W)) u_piece (
    .off_i    (addr_q[SLOT_W-1:0]),
    .rem_i    (rem_q),
    .single_i (single),
    .cnt_o    (cnt),
    .mask_o   (exact),
    .aligned_o(aligned),
    .whole_o  (whole),
    .eol_o    (eol)
  );

  dwsel_type u_type (
    .cls_i    (cls_q),
    .mode_i   (mode_q),
    .aligned_i(aligned),
    .whole_i  (whole),
    .eol_i    (eol),
    .wt_o     (wt),
    .pad_o    (pad)
  );

  // invalid codes fall back to mode 0
  always_comb begin
    mode_in = 2'd0;
    bad_in  = 1'b0;
    case (cls_e'(req_cls_i))
      CLS_STS: if (cfg_sts_i == 2'd3) bad_in = 1'b1; else mode_in = cfg_sts_i;
      CLS_CMP: if (cfg_cmp_i == 2'd3) bad_in = 1'b1; else mode_in = cfg_cmp_i;
      CLS_PRM: mode_in = cfg_prm_i;
      default: mode_in = {1'b0, cfg_out_i};
    endcase
  end

  assign accept = req_valid_i && !busy_q;
  assign fire   = busy_q && out_ready_i;
  assign last   = single || (rem_q == LEN_W'(cnt));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      err_q  <= 1'b0;
      addr_q <= '0;
      rem_q  <= '0;
      cls_q  <= 2'd0;
      mode_q <= 2'd0;
      wrd_q  <= '0;
    end else if (accept) begin
      err_q <= err_q | bad_in;
      if (req_len_i != '0) begin
        busy_q <= 1'b1;
        addr_q <= req_addr_i;
        rem_q  <= req_len_i;
        cls_q  <= req_cls_i;
        mode_q <= mode_in;
        wrd_q  <= req_wrd_i;
      end
    end else if (fire) begin
      if (last) begin
        busy_q <= 1'b0;
      end else begin
        addr_q <= addr_q + ADDR_W'(cnt);
        rem_q  <= rem_q - LEN_W'(cnt);
      end
    end
  end

  assign req_ready_o = !busy_q;
  assign out_valid_o = busy_q;
  assign out_line_o  = addr_q[ADDR_W-1:SLOT_W];
  assign out_mask_o  = pad ? '1 : exact;
  assign out_type_o  = wt;
  assign out_last_o  = last;
  assign out_wrd_o   = wrd_q;
  assign cfg_err_o   = err_q;
endmodule

// File: rtl/dwsel_chk.sv
`timescale 1ns/1ps
module dwsel_chk #(
  parameter int LINE_W = 8,
  parameter int SLOTS  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [LINE_W-1:0] out_line_o,
  input logic [SLOTS-1:0]  out_mask_o,
  input logic [1:0]        out_type_o,
  input logic              out_last_o,
  input logic              cfg_err_o,
  input logic [1:0]        cls_q
);
  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_line_o) &&
    $stable(out_mask_o) && $stable(out_type_o) && $stable(out_last_o));

  assert_one_req_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_ready_o && out_valid_o));

  assert_sticky_err_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |=> cfg_err_o);

  assert_mask_live_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $countones(out_mask_o) > 0);

  assert_type_code_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> out_type_o != 2'd3);

  assert_cmp_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && cls_q == 2'd1 |-> out_last_o);

  assert_full_line_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_type_o == 2'd1 && cls_q != 2'd0 |-> &out_mask_o);
endmodule

bind dwsel_top dwsel_chk #(.LINE_W(LINE_W), .SLOTS(SLOTS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_ready_o(req_ready_o),
  .out_valid_o(out_valid_o),
  .out_ready_i(out_ready_i),
  .out_line_o (out_line_o),
  .out_mask_o (out_mask_o),
  .out_type_o (out_type_o),
  .out_last_o (out_last_o),
  .cfg_err_o  (cfg_err_o),
  .cls_q      (cls_q)
);

// File: tb/sim_dwsel_top.sv
`timescale 1ns/1ps
module sim_dwsel_top;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, out_ready = 1'b0, cfg_out = 1'b0;
  logic [1:0]  req_cls = 2'd0, cfg_sts = 2'd0, cfg_cmp = 2'd0, cfg_prm = 2'd0;
  logic [11:0] req_addr = '0;
  logic [7:0]  req_len = '0;
  logic [63:0] req_wrd = '0;
  logic        req_ready, out_valid, out_last, cfg_err;
  logic [7:0]  out_line;
  logic [15:0] out_mask;
  logic [1:0]  out_type;
  logic [63:0] out_wrd;

  int total = 0, bad = 0, tick = 0;
  bit exp_err = 1'b0;

  always #2 clk = ~clk;

  dwsel_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_cls_i(req_cls), .req_addr_i(req_addr), .req_len_i(req_len), .req_wrd_i(req_wrd),
    .cfg_sts_i(cfg_sts), .cfg_cmp_i(cfg_cmp), .cfg_prm_i(cfg_prm), .cfg_out_i(cfg_out),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_line_o(out_line),
    .out_mask_o(out_mask), .out_type_o(out_type), .out_last_o(out_last),
    .out_wrd_o(out_wrd), .cfg_err_o(cfg_err)
  );

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_req(int cls, int mode, int a, int len, bit throttle);
    int cur, rem, off, n, eff, ty, exp_line;
    bit done, aligned, whole, eol, pad, lst;
    logic [15:0] mask;
    logic [63:0] w;
    string rq;
    w = {32'hC0DE0000 | 32'(a), 32'(len * 3 + cls)};
    rq = (cls == 0) ? "R2" : (cls == 1) ? "R3" : (cls == 3) ? "R6" : (mode < 2) ? "R4" : "R5";
    @(negedge clk);
    req_valid = 1'b1; req_cls = 2'(cls); req_addr = 12'(a); req_len = 8'(len); req_wrd = w;
    cfg_sts = (cls == 0) ? 2'(mode) : 2'd0;
    cfg_cmp = (cls == 1) ? 2'(mode) : 2'd0;
    cfg_prm = (cls == 2) ? 2'(mode) : 2'd0;
    cfg_out = (cls == 3) ? mode[0] : 1'b0;
    #1 chk(req_ready == 1'b1, "R9", "ready before request", req_ready, 1);
    @(posedge clk);
    if (cls <= 1 && mode == 3) exp_err = 1'b1;
    eff = (cls <= 1 && mode == 3) ? 0 : (cls == 3 ? (mode & 1) : mode);
    cur = a; rem = len; done = (len == 0);
    if (done) begin
      @(negedge clk);
      req_valid = 1'b0;
      #1 chk(out_valid == 1'b0 && req_ready == 1'b1, "R10", "empty request", {out_valid, req_ready}, 1);
      chk(cfg_err == exp_err, "R7", "err flag", cfg_err, exp_err);
    end
    while (!done) begin
      @(negedge clk);
      req_valid = 1'b0;
      tick++;
      out_ready = throttle ? ((tick % 4) != 1) : 1'b1;
      #1;
      off = cur % 16;
      n = (cls == 1) ? 1 : ((rem < 16 - off) ? rem : 16 - off);
      aligned = (off == 0); whole = aligned && n == 16; eol = (off + n == 16);
      ty = 0; pad = 1'b0;
      case (cls)
        0: if (eol && eff == 1) ty = 2; else if (eol && eff == 2) ty = 1;
        1: if (eff != 0) begin ty = (eff == 1) ? 2 : 1; pad = 1'b1; end
        2: case (eff)
             0: ty = whole ? 1 : 0;
             1: if (aligned) begin ty = 1; pad = 1'b1; end
             2: ty = whole ? 2 : 0;
             default: if (aligned) begin ty = 2; pad = 1'b1; end
           endcase
        default: ty = whole ? (eff == 1 ? 2 : 1) : 0;
      endcase
      mask = pad ? 16'hFFFF : 16'(((32'd1 << n) - 1) << off);
      lst = (cls == 1) || (rem == n);
      exp_line = cur / 16;
      chk(out_valid == 1'b1 && req_ready == 1'b0, "R9", "busy handshake", {out_valid, req_ready}, 2);
      chk(out_line == 8'(exp_line) && out_mask == mask && out_last == lst, "R1",
          "line/mask/last", {out_line, out_mask, out_last}, {8'(exp_line), mask, lst});
      chk(out_type == 2'(ty), rq, "type", out_type, ty);
      if (cls == 1) chk(out_wrd == w, "R3", "completion word", out_wrd, w);
      chk(cfg_err == exp_err, "R7", "err flag", cfg_err, exp_err);
      if (!out_ready) chk(1'b1, "R8", "held", 0, 0);
      @(posedge clk);
      if (out_ready) begin
        if (lst) done = 1'b1;
        cur += n; rem -= n;
      end
    end
  endtask

  initial begin
    #(4 * 190000);
    chk(1'b0, "watchdog", "run hung", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int lens[10] = '{0, 1, 2, 3, 7, 15, 16, 17, 31, 33};
    repeat (3) @(posedge clk);
    #1 chk(out_valid == 0 && req_ready == 1 && cfg_err == 0, "R11", "reset state",
           {out_valid, req_ready, cfg_err}, 3'b010);
    @(negedge clk) rst_n = 1'b1;
    // classes without invalid codes first, so the error flag starts clear
    for (int ci = 0; ci < 4; ci++) begin
      int cls;
      cls = (ci + 2) % 4;
      for (int m = 0; m < (cls == 3 ? 2 : 4); m++)
        for (int off = 0; off < 16; off++)
          for (int li = 0; li < 10; li++)
            run_req(cls, m, 80 + off, lens[li], ((off + li) % 2) == 1);
    end
    @(negedge clk);
    #1 chk(cfg_err == 1'b1 && req_ready == 1'b1, "R7", "sticky err at end", cfg_err, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule